// File: doc/BRIEF.md
# Multi-channel periodic interrupt timer

This peripheral holds several independent down-counting timer channels behind a small register bus. Software gives each channel a load value and turns it on. The channel then counts down on every clock. When it reaches zero it raises a timeout flag, refills itself from the load value and keeps running. Each channel drives its own interrupt line. The line is raised when both the flag and the channel's interrupt enable are set, and it stays up until software clears the flag.

A channel can be chained to the channel below it. A chained channel steps once for each expiry of its lower neighbour, so a pair of channels forms one wide counter. A single module-level disable bit freezes every channel at once. The bus has a one-cycle read latency: read data is registered from the address presented at the previous clock edge.

Register map. Address 0x000 is the module control register, where bit 1 is the module disable. Channel n occupies 0x100 + 0x10*n and holds four registers:
- +0x0: load value
- +0x4: current count
- +0x8: control (bit 0 run, bit 1 interrupt enable, bit 2 chain)
- +0xC: flag (bit 0 timeout)

Top module: `mpt_timer`

## Requirements
- R1: After reset, the module control register reads 2 (module disable set), every channel register reads 0 and all interrupt lines are low.
- R2: A running channel with load value N sets its flag every N+1 cycles. Its interrupt (with the interrupt enable set) rises N+2 cycles after the clock edge that wrote the run bit.
- R3: A load-value write while the channel runs leaves the current period unchanged. The new value governs the periods after the next reload.
- R4: While the run bit is 0, the count holds. Setting the run bit from 0 to 1 loads the count from the load register at that same edge.
- R5: While the module disable (bit 1 at 0x000) is 1, no channel's count changes, except for the reload on a 0-to-1 run-bit write.
- R6: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged. A timeout in the same cycle wins over a clear.
- R7: A channel's interrupt line equals flag AND interrupt enable, registered one cycle later. It stays high until the flag is cleared.
- R8: A channel n>0 with the chain bit (control bit 2) set steps only on the expiry of channel n-1, so it expires every (M+1)(N+1) cycles, where M is its own load value and N is the lower channel's. Channel 0 ignores its chain bit.
- R9: The current-count register is read-only, and writes to it change nothing.
- R10: Only control bits 2:0 are stored. Unmapped addresses read as 0. Each write reaches at most one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (12) | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data for the address presented at the previous edge |
| irq | output | NCH (4) | Per-channel interrupt lines |

## Verification
On every cycle, the assertions check the following:
- A stopped, frozen or unticked chained channel keeps its count.
- An expiry is followed by a count equal to the load value.
- A flag rises only on an expiry.
- An interrupt line only follows a set flag with the interrupt enable on.
- The decoder strobes at most one register per write.

Exact period lengths, the deferred effect of a load write, and the count frozen by a disable or the module disable can only be shown by the bench's timed scenarios. The same holds for the chained expiry period, the write-one-to-clear behaviour and the ignored writes. The bench sweeps load values on all four channels for these.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  localparam int MCR_OFF     = 'h000;
  localparam int CH_BASE_OFF = 'h100;
  localparam int OFF_LOAD    = 'h0;
  localparam int OFF_COUNT   = 'h4;
  localparam int OFF_CTRL    = 'h8;
  localparam int OFF_FLAG    = 'hC;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_MCR,
    RK_LOAD,
    RK_COUNT,
    RK_CTRL,
    RK_FLAG
  } rkind_e;

  typedef struct packed {
    logic chain;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/mpt_decode.sv
module mpt_decode
  import mpt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 12,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  addr_i,
  input  logic           we_i,
  output rkind_e         rkind_o,
  output logic [CHW-1:0] rch_o,
  output logic           mcr_we_o,
  output logic [NCH-1:0] ld_we_o,
  output logic [NCH-1:0] ctrl_we_o,
  output logic [NCH-1:0] flg_we_o
);
  localparam logic [AW-1:0]   CH_BASE = AW'(CH_BASE_OFF);
  localparam logic [AW-5:0]   NCH_L   = (AW-4)'(NCH);

  logic [AW-1:0] rel;
  logic [AW-5:0] slot;
  logic [3:0]    off;
  logic          in_ch;

  assign rel   = addr_i - CH_BASE;
  assign slot  = rel[AW-1:4];
  assign off   = rel[3:0];
  assign in_ch = (addr_i >= CH_BASE) && (slot < NCH_L);
  assign rch_o = slot[CHW-1:0];

  always_comb begin
    rkind_o = RK_NONE;
    if (addr_i == AW'(MCR_OFF)) begin
      rkind_o = RK_MCR;
    end else if (in_ch) begin
      case (off)
        4'(OFF_LOAD):  rkind_o = RK_LOAD;
        4'(OFF_COUNT): rkind_o = RK_COUNT;
        4'(OFF_CTRL):  rkind_o = RK_CTRL;
        4'(OFF_FLAG):  rkind_o = RK_FLAG;
        default:       rkind_o = RK_NONE;
      endcase
    end
  end

  assign mcr_we_o = we_i && (rkind_o == RK_MCR);

  for (genvar i = 0; i < NCH; i++) begin : g_we
    logic hit;
    assign hit          = we_i && (rch_o == CHW'(i));
    assign ld_we_o[i]   = hit && (rkind_o == RK_LOAD);
    assign ctrl_we_o[i] = hit && (rkind_o == RK_CTRL);
    assign flg_we_o[i]  = hit && (rkind_o == RK_FLAG);
  end

  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mcr_we_o, ld_we_o, ctrl_we_o, flg_we_o}));
endmodule

// File: rtl/mpt_channel.sv
module mpt_channel
  import mpt_pkg::*;
#(
  parameter int CW  = 32,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mdis_i,
  input  logic          ld_we_i,
  input  logic          ctrl_we_i,
  input  logic          flg_we_i,
  input  logic [CW-1:0] ld_wd_i,
  input  ctrl_t         ctrl_wd_i,
  input  logic          flg_clr_i,
  input  logic          prev_exp_i,
  output logic          exp_o,
  output logic [CW-1:0] load_o,
  output logic [CW-1:0] cnt_o,
  output ctrl_t         ctrl_o,
  output logic          flag_o,
  output logic          irq_o
);
  localparam bit CAN_CHAIN = (IDX > 0);

  logic [CW-1:0] load_q, cnt_q;
  ctrl_t         ctrl_q;
  logic          flag_q, irq_q;
  logic          chain_act, tick, run, at_zero, en_rise;

  if (CAN_CHAIN) begin : g_chain
    assign chain_act = ctrl_q.chain;
  end else begin : g_nochain
    assign chain_act = 1'b0;
  end

  assign tick    = chain_act ? prev_exp_i : 1'b1;
  assign run     = ctrl_q.en && !mdis_i;
  assign at_zero = (cnt_q == '0);
  assign exp_o   = run && tick && at_zero;
  assign en_rise = ctrl_we_i && ctrl_wd_i.en && !ctrl_q.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ld_we_i) load_q <= ld_wd_i;
      if (ctrl_we_i) ctrl_q <= ctrl_wd_i;
      if (en_rise) begin
        cnt_q <= load_q;
      end else if (run && tick) begin
        cnt_q <= at_zero ? load_q : cnt_q - 1'b1;
      end
      if (exp_o) begin
        flag_q <= 1'b1;
      end else if (flg_we_i && flg_clr_i) begin
        flag_q <= 1'b0;
      end
      irq_q <= flag_q && ctrl_q.ie;
    end
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.en && !ctrl_we_i) |=> $stable(cnt_q));
  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (mdis_i && !ctrl_we_i) |=> $stable(cnt_q));
  // R2
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    exp_o |=> (cnt_q == $past(load_q)));
  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(exp_o));
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(flag_q && ctrl_q.ie));

  if (CAN_CHAIN) begin : g_chain_chk
    // R8
    chain_step_chk: assert property (@(posedge clk) disable iff (rst)
      (ctrl_q.chain && !prev_exp_i && !ctrl_we_i) |=> $stable(cnt_q));
  end
endmodule

// File: rtl/mpt_timer.sv
module mpt_timer
  import mpt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int CW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  rkind_e         rkind;
  logic [CHW-1:0] rch;
  logic           mcr_we;
  logic [NCH-1:0] ld_we, ctrl_we, flg_we;
  logic           mdis_q;

  logic [CW-1:0]  load_a [NCH];
  logic [CW-1:0]  cnt_a  [NCH];
  ctrl_t          ctrl_a [NCH];
  logic [NCH-1:0] flag_v, exp_v, irq_v;

  mpt_decode #(.NCH(NCH), .AW(AW), .CHW(CHW)) dec_i (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (bus_addr),
    .we_i      (bus_we),
    .rkind_o   (rkind),
    .rch_o     (rch),
    .mcr_we_o  (mcr_we),
    .ld_we_o   (ld_we),
    .ctrl_we_o (ctrl_we),
    .flg_we_o  (flg_we)
  );

  always_ff @(posedge clk) begin
    if (rst) mdis_q <= 1'b1;
    else if (mcr_we) mdis_q <= bus_wdata[1];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic prev_exp;
    if (i == 0) begin : g_first
      assign prev_exp = 1'b0;
    end else begin : g_next
      assign prev_exp = exp_v[i-1];
    end

    mpt_channel #(.CW(CW), .IDX(i)) ch_i (
      .clk        (clk),
      .rst        (rst),
      .mdis_i     (mdis_q),
      .ld_we_i    (ld_we[i]),
      .ctrl_we_i  (ctrl_we[i]),
      .flg_we_i   (flg_we[i]),
      .ld_wd_i    (bus_wdata[CW-1:0]),
      .ctrl_wd_i  (ctrl_t'(bus_wdata[2:0])),
      .flg_clr_i  (bus_wdata[0]),
      .prev_exp_i (prev_exp),
      .exp_o      (exp_v[i]),
      .load_o     (load_a[i]),
      .cnt_o      (cnt_a[i]),
      .ctrl_o     (ctrl_a[i]),
      .flag_o     (flag_v[i]),
      .irq_o      (irq_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (rkind)
        RK_MCR:   bus_rdata <= DW'({mdis_q, 1'b0});
        RK_LOAD:  bus_rdata <= DW'(load_a[rch]);
        RK_COUNT: bus_rdata <= DW'(cnt_a[rch]);
        RK_CTRL:  bus_rdata <= DW'(ctrl_a[rch]);
        RK_FLAG:  bus_rdata <= DW'(flag_v[rch]);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign irq = irq_v;
endmodule

// File: tb/mpt_timer_tb_top.sv
module mpt_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 12;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [AW-1:0]  addr = '0;
  logic           we = 1'b0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic [NCH-1:0] irq;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int last_cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mpt_timer #(.NCH(NCH), .AW(AW), .DW(DW), .CW(32)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq       (irq)
  );

  function automatic int ra(int ch, int off);
    return 'h100 + 'h10 * ch + off;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
    last_cyc = cyc;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = AW'(a);
    @(posedge clk); @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wait_irq(int ch, int maxc, output int at);
    at = -1;
    for (int k = 0; k < maxc; k++) begin
      if (irq[ch]) begin at = cyc; break; end
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic stop_ch(int ch);
    wr(ra(ch, 'h8), 0);
    wr(ra(ch, 'hC), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int e, d, at, m0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, v); chk("R1 mcr", v, 2);
    for (int ch = 0; ch < NCH; ch++) begin
      for (int o = 0; o < 16; o += 4) begin
        rd(ra(ch, o), v); chk("R1 chreg", v, 0);
      end
    end
    chk("R1 irq", 32'(irq), 0);
    wr(0, 0);

    // R10 decode and storage width
    rd(4, v); chk("R10 unmapped 0x4", v, 0);
    rd('hF0, v); chk("R10 unmapped 0xF0", v, 0);
    rd(ra(4, 0), v); chk("R10 beyond last channel", v, 0);
    wr(ra(3, 0), 32'hDEADBEEF);
    rd(ra(3, 0), v); chk("R10 load readback", v, 32'hDEADBEEF);
    rd(ra(2, 0), v); chk("R10 neighbour untouched", v, 0);
    wr(ra(3, 'h8), 32'hFFFFFFF6);
    rd(ra(3, 'h8), v); chk("R10 ctrl bits", v, 6);
    wr(ra(3, 'h8), 0);

    // R2 period sweep on every channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int n = 1; n <= 6; n++) begin
        wr(ra(ch, 0), n);
        wr(ra(ch, 'h8), 3);
        e = last_cyc;
        wait_irq(ch, 60, at);
        chk("R2 first expiry", at, e + n + 2);
        if (n >= 2) begin
          wr(ra(ch, 'hC), 1);
          idle(1);
          wait_irq(ch, 60, at);
          chk("R2 reload period", at, e + 2 * (n + 1) + 1);
        end
        stop_ch(ch);
      end
    end

    // R3 deferred load value
    wr(ra(1, 0), 9);
    wr(ra(1, 'h8), 3);
    e = last_cyc;
    wr(ra(1, 0), 3);
    wait_irq(1, 60, at);
    chk("R3 current period kept", at, e + 11);
    wr(ra(1, 'hC), 1);
    idle(1);
    wait_irq(1, 60, at);
    chk("R3 new load after reload", at, e + 15);
    stop_ch(1);

    // R4 hold while stopped, reload on enable
    wr(ra(2, 0), 100);
    wr(ra(2, 'h8), 1);
    e = last_cyc;
    idle(5);
    wr(ra(2, 'h8), 0);
    d = last_cyc;
    rd(ra(2, 4), v); chk("R4 count at stop", v, 100 - (d - e));
    idle(3);
    rd(ra(2, 4), v2); chk("R4 count held", v2, v);
    wr(ra(2, 0), 50);
    wr(ra(2, 'h8), 1);
    wr(ra(2, 'h8), 0);
    rd(ra(2, 4), v); chk("R4 reenable reload", v, 49);

    // R9 count is read-only
    wr(ra(2, 4), 32'h1234);
    rd(ra(2, 4), v); chk("R9 count write ignored", v, 49);

    // R5 module disable freezes
    wr(ra(2, 'h8), 1);
    e = last_cyc;
    wr(0, 2);
    m0 = last_cyc;
    rd(ra(2, 4), v); chk("R5 count at freeze", v, 50 - (m0 - e));
    idle(6);
    rd(ra(2, 4), v2); chk("R5 count frozen", v2, v);
    rd(0, v); chk("R5 mcr readback", v, 2);
    wr(0, 0);
    stop_ch(2);

    // R6 write-one-to-clear
    wr(ra(0, 0), 2);
    wr(ra(0, 'h8), 1);
    idle(5);
    wr(ra(0, 'h8), 0);
    rd(ra(0, 'hC), v); chk("R6 flag set", v, 1);
    wr(ra(0, 'hC), 0);
    rd(ra(0, 'hC), v); chk("R6 write 0 no effect", v, 1);
    wr(ra(0, 'hC), 1);
    rd(ra(0, 'hC), v); chk("R6 write 1 clears", v, 0);

    // R7 interrupt = flag AND enable, held until clear
    wr(ra(0, 'h8), 1);
    idle(5);
    wr(ra(0, 'h8), 0);
    idle(2);
    chk("R7 no irq without enable", 32'(irq[0]), 0);
    wr(ra(0, 'h8), 2);
    idle(1);
    chk("R7 irq with enable", 32'(irq[0]), 1);
    idle(10);
    chk("R7 irq held", 32'(irq[0]), 1);
    wr(ra(0, 'hC), 1);
    idle(1);
    chk("R7 irq drops after clear", 32'(irq[0]), 0);
    wr(ra(0, 'h8), 0);

    // R8 chaining sweep: ch1 on ch0, ch3 on ch2
    for (int p = 0; p < 2; p++) begin
      for (int m = 1; m <= 3; m++) begin
        wr(ra(2 * p + 1, 0), m);
        wr(ra(2 * p + 1, 'h8), 7);
        wr(ra(2 * p, 0), 2);
        rd(ra(2 * p + 1, 4), v);
        idle(3);
        rd(ra(2 * p + 1, 4), v2); chk("R8 chained holds without ticks", v2, v);
        wr(ra(2 * p, 'h8), 1);
        e = last_cyc;
        wait_irq(2 * p + 1, 80, at);
        chk("R8 chained period", at, e + 3 * (m + 1) + 1);
        chk("R8 lower irq quiet", 32'(irq[2 * p]), 0);
        stop_ch(2 * p);
        stop_ch(2 * p + 1);
      end
    end
    wr(ra(0, 0), 3);
    wr(ra(0, 'h8), 7);
    e = last_cyc;
    wait_irq(0, 60, at);
    chk("R8 channel 0 ignores chain", at, e + 5);
    stop_ch(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule